// File: doc/BRIEF.md
# Sticky Busy/Idle Status Flag

This block pairs a small sample control state machine with a one-bit status flag that records whether the machine has been active since software last looked. Each state code is either an idle code or an active code, according to a membership mask parameter. The flag turns on as soon as the machine enters an active code. It turns off only when a status read lands while the machine is sitting in an idle code. A host that polls the flag therefore learns one of two things. A 1 means activity happened at some point in the last poll interval. A 0 means the machine stayed idle for the whole of that interval.

Reads use a simple registered port. A read of the status address returns the flag as it stood before the read's own clear. An optional counter, selected by a parameter, counts consecutive status reads that returned 0. Any status read that returns 1 resets it. A power controller can read this counter to tell how many full poll intervals the device has been quiet. The sample machine accepts a job of programmable length, works through a setup, run and drain sequence, and then passes through a parking code before it rests. Both the parking code and the rest code count as idle by default.

Top module: `busy_sense_top`

## Requirements
- R1: After reset the flag reads 0, the idle-poll counter reads 0, `rd_valid` is low and `core_idle` is high.
- R2: A job pulse with length L, given while the machine is idle, holds `core_idle` low for exactly L+3 cycles. Job pulses that arrive while the machine is active are ignored and do not lengthen this period.
- R3: Whenever the machine is in an active code, the flag is 1. A status read taken after any activity returns 1 in bit 0.
- R4: A status read (address 0) clears the flag only if the machine is idle in the cycle of the read and stays idle on the following edge. With no new activity, the next status read then returns 0.
- R5: A status read taken while the machine is active does not clear the flag. The first status read after the machine returns to idle still returns 1.
- R6: Every read returns its data with `rd_valid` high exactly one cycle after `rd_en`. A status read returns the flag value from before that read's clear, in bit 0, with the upper bits zero.
- R7: When a status read and a job pulse arrive in the same cycle with the flag at 0, the read returns 0. The flag becomes 1, and the next status read returns 1.
- R8: The idle-poll counter, read at address 1 and zero-extended, increases by one on each status read that returns 0 and saturates at its maximum value (255 by default). It is cleared by each status read that returns 1.
- R9: A read of any address other than 0 or 1 returns 0 and changes neither the flag nor the counter.
- R10: A read of the counter address does not clear the flag and does not change the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| job_go | input | 1 | Starts a job when the machine is idle |
| job_len | input | LEN_W | Run length of the job, in cycles minus one |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | ADDR_W | Read address: 0 is the flag, 1 is the idle-poll counter |
| rd_valid | output | 1 | Read data is valid this cycle |
| rd_data | output | DATA_W | Read data |
| core_idle | output | 1 | The machine currently sits in an idle code |

## Verification
The properties assume two things about the inputs. First, a read strobe is a single-cycle pulse with a stable address. Second, reset is held long enough to bring the machine to its rest code. The property that ties a falling flag to an idle status read also assumes that nothing but reset and a status read can lower the flag. The stimulus issues every read as a one-cycle strobe followed by a quiet cycle, and it starts jobs only through the job pulse. It holds reset for several cycles before any traffic. The corner where a read and a job pulse coincide is driven on purpose, in the same cycle, so that both the set path and the clear path meet in one edge.

// File: rtl/busy_sense_pkg.sv
// Package: shared state codes, register addresses and sizes for the sticky
// busy/idle flag block. Assumes a 3-bit state code space.
package busy_sense_pkg;
    localparam int STATE_W   = 3;
    localparam int NUM_CODES = 1 << STATE_W;

    typedef enum logic [STATE_W-1:0] {
        ST_REST  = 3'd0,
        ST_PARK  = 3'd1,
        ST_SETUP = 3'd2,
        ST_RUN   = 3'd3,
        ST_DRAIN = 3'd4
    } ctl_state_e;

    // Rest and park are idle by default.
    localparam logic [NUM_CODES-1:0] DEFAULT_IDLE_SET = 8'b0000_0011;

    localparam int STATUS_REG = 0;
    localparam int COUNT_REG  = 1;
endpackage

// File: rtl/busy_sense_fsm.sv
// Sample peripheral control machine. A job pulse in an idle code loads the
// run length and walks setup -> run (len+1 cycles) -> drain -> park -> rest.
// Reports whether the current and next state codes belong to the idle set.
// Assumes job_len is sampled only in the cycle job_go is seen in an idle code.
module busy_sense_fsm
    import busy_sense_pkg::*;
#(
    parameter int                     LEN_W    = 8,
    parameter logic [NUM_CODES-1:0]   IDLE_SET = DEFAULT_IDLE_SET
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             job_go,
    input  logic [LEN_W-1:0] job_len,
    output logic             idle_now,
    output logic             idle_next
);
    ctl_state_e       state_q, state_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;

    // Next-state and run-length countdown.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        case (state_q)
            ST_REST, ST_PARK: begin
                if (job_go) begin
                    state_d = ST_SETUP;
                    cnt_d   = job_len;
                end else if (state_q == ST_PARK) begin
                    state_d = ST_REST;
                end
            end
            ST_SETUP: state_d = ST_RUN;
            ST_RUN: begin
                if (cnt_q == '0) state_d = ST_DRAIN;
                else             cnt_d   = cnt_q - 1'b1;
            end
            ST_DRAIN: state_d = ST_PARK;
            default:  state_d = ST_REST;
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_REST;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Idle-set membership lookup on the present and next code.
    always_comb begin
        idle_now  = IDLE_SET[state_q];
        idle_next = IDLE_SET[state_d];
    end
endmodule

// File: rtl/busy_sense_flag.sv
// Sticky flag: set on entry to (or stay in) any active code, cleared by a
// status poll only while the machine is idle now and on the next edge.
// Assumes poll_rd is a one-cycle strobe.
module busy_sense_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic idle_now,
    input  logic idle_next,
    input  logic poll_rd,
    output logic flag_q
);
    // Set has priority over the poll clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                    flag_q <= 1'b0;
        else if (!idle_next)           flag_q <= 1'b1;
        else if (poll_rd && idle_now)  flag_q <= 1'b0;
    end
endmodule

// File: rtl/busy_sense_pollcnt.sv
// Counts consecutive status polls that saw the flag at 0; a poll that saw 1
// clears it. Saturates at all ones. Assumes flag_seen is the pre-clear flag.
module busy_sense_pollcnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             poll_rd,
    input  logic             flag_seen,
    output logic [CNT_W-1:0] count_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Consecutive idle-poll tally.
    always_ff @(posedge clk) begin
        if (!rst_n)                     count_q <= '0;
        else if (poll_rd && flag_seen)  count_q <= '0;
        else if (poll_rd && count_q != CNT_MAX) count_q <= count_q + 1'b1;
    end
endmodule

// File: rtl/busy_sense_top.sv
// Top: sample machine, sticky flag, optional idle-poll counter and a
// registered read port (one-cycle latency). Assumes CNT_W <= DATA_W and
// single-cycle read strobes.
module busy_sense_top
    import busy_sense_pkg::*;
#(
    parameter int                   LEN_W    = 8,
    parameter int                   ADDR_W   = 4,
    parameter int                   DATA_W   = 16,
    parameter int                   CNT_W    = 8,
    parameter bit                   COUNT_EN = 1'b1,
    parameter logic [NUM_CODES-1:0] IDLE_SET = DEFAULT_IDLE_SET
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              job_go,
    input  logic [LEN_W-1:0]  job_len,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              core_idle
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(STATUS_REG);
    localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(COUNT_REG);

    logic             idle_now, idle_next;
    logic             status_flag;
    logic             poll_rd, count_rd;
    logic [CNT_W-1:0] poll_count;

    busy_sense_fsm #(.LEN_W(LEN_W), .IDLE_SET(IDLE_SET)) u_fsm (
        .clk(clk), .rst_n(rst_n), .job_go(job_go), .job_len(job_len),
        .idle_now(idle_now), .idle_next(idle_next)
    );

    // Address decode of the read strobe.
    always_comb begin
        poll_rd  = rd_en && (rd_addr == A_STATUS);
        count_rd = rd_en && (rd_addr == A_COUNT);
    end

    busy_sense_flag u_flag (
        .clk(clk), .rst_n(rst_n), .idle_now(idle_now), .idle_next(idle_next),
        .poll_rd(poll_rd), .flag_q(status_flag)
    );

    generate
        if (COUNT_EN) begin : g_cnt
            busy_sense_pollcnt #(.CNT_W(CNT_W)) u_cnt (
                .clk(clk), .rst_n(rst_n), .poll_rd(poll_rd),
                .flag_seen(status_flag), .count_q(poll_count)
            );
        end else begin : g_nocnt
            assign poll_count = '0;
        end
    endgenerate

    // Registered read return, pre-clear value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                if (poll_rd)       rd_data <= DATA_W'(status_flag);
                else if (count_rd) rd_data <= DATA_W'(poll_count);
                else               rd_data <= '0;
            end
        end
    end

    assign core_idle = idle_now;
endmodule

// File: rtl/busy_sense_chk.sv
// Checker for busy_sense_top, bound below. Assumes single-cycle read strobes.
module busy_sense_chk #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 16,
    parameter int CNT_W    = 8,
    parameter bit COUNT_EN = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              core_idle,
    input logic              status_flag,
    input logic [CNT_W-1:0]  poll_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    p_active_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !core_idle |-> status_flag);

    p_clear_on_idle_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_flag) |-> $past(rd_en && rd_addr == '0 && core_idle));

    p_valid_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    p_no_stray_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    p_pre_clear_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == '0) |=> (rd_data[0] == $past(status_flag)));

    p_busy_poll_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (COUNT_EN && rd_en && rd_addr == '0 && status_flag) |=> (poll_count == '0));

    p_idle_poll_steps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (COUNT_EN && rd_en && rd_addr == '0 && !status_flag && poll_count != CNT_MAX)
        |=> (poll_count == $past(poll_count) + 1'b1));

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr > ADDR_W'(1)) |=> (rd_data == '0));
endmodule

bind busy_sense_top busy_sense_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .COUNT_EN(COUNT_EN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .core_idle(core_idle),
    .status_flag(status_flag), .poll_count(poll_count)
);

// File: tb/busy_sense_top_bench.sv
`timescale 1ns/1ps
module busy_sense_top_bench;
    localparam int LEN_W = 8, ADDR_W = 4, DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              job_go = 1'b0;
    logic [LEN_W-1:0]  job_len = '0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic              core_idle;

    busy_sense_top u_busy_sense_top (
        .clk(clk), .rst_n(rst_n), .job_go(job_go), .job_len(job_len),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_data(rd_data), .core_idle(core_idle)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct { int data; int cyc; int req; } item_t;
    item_t sb[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input int req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every returned read.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, 6, "read data with nothing pending", 1, 0); // R6
            end else begin
                item_t it;
                it = sb.pop_front();
                chk(int'(rd_data) == it.data, it.req, "read data", int'(rd_data), it.data);
                chk(cyc == it.cyc, 6, "read latency cycle", cyc, it.cyc); // R6
            end
        end
    end

    // Driver: one read strobe, expected value queued.
    task automatic do_read(input int addr, input int exp, input int req);
        item_t it;
        it.data = exp; it.cyc = cyc + 1; it.req = req;
        sb.push_back(it);
        rd_en = 1'b1; rd_addr = ADDR_W'(addr);
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_job(input int len);
        job_go = 1'b1; job_len = LEN_W'(len);
        @(negedge clk);
        job_go = 1'b0;
    endtask

    task automatic wait_idle();
        while (!core_idle) @(negedge clk);
    endtask

    // R2: measure the active period, optionally poking job_go mid-job.
    task automatic timed_job(input int len, input bit poke);
        int busy;
        busy = 0;
        pulse_job(len);
        while (!core_idle) begin
            busy++;
            job_go = (poke && busy == 2);
            @(negedge clk);
        end
        job_go = 1'b0;
        chk(busy == len + 3, 2, "active period length", busy, len + 3);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(core_idle == 1'b1, 1, "core_idle after reset", core_idle, 1);
        chk(rd_valid == 1'b0, 1, "rd_valid after reset", rd_valid, 0);
        do_read(1, 0, 1);          // R1 counter 0
        do_read(0, 0, 1);          // R1 flag 0, counter -> 1
        do_read(0, 0, 8);          // R8 counter -> 2
        do_read(1, 2, 8);          // R8 two idle polls
        timed_job(4, 1'b0);        // R2
        do_read(1, 2, 10);         // R10 counter read leaves flag/counter
        do_read(0, 1, 3);          // R3 activity seen; clears, counter 0
        do_read(0, 0, 4);          // R4 cleared; counter 1
        do_read(1, 1, 8);          // R8
        // R5: read while active does not clear
        pulse_job(10);
        do_read(0, 1, 5);
        wait_idle();
        do_read(0, 1, 5);          // R5 still set
        do_read(0, 0, 4);          // R4 counter -> 1
        timed_job(6, 1'b1);        // R2 ignored mid-job pulse
        do_read(0, 1, 3);          // R3
        // R7: read and job pulse in the same cycle, flag was 0
        begin
            item_t it;
            it.data = 0; it.cyc = cyc + 1; it.req = 7;
            sb.push_back(it);
            rd_en = 1'b1; rd_addr = '0; job_go = 1'b1; job_len = 8'd3;
            @(negedge clk);
            rd_en = 1'b0; job_go = 1'b0;
        end
        wait_idle();
        @(negedge clk);
        do_read(0, 1, 7);          // R7 flag stayed set; counter 0
        do_read(3, 0, 9);          // R9 unmapped
        do_read(9, 0, 9);          // R9 unmapped
        do_read(0, 0, 9);          // R9 flag untouched; counter 1
        do_read(1, 1, 9);          // R9 counter untouched
        // R8 saturation
        for (int i = 0; i < 300; i++) do_read(0, 0, 8);
        do_read(1, 255, 8);        // R8 saturated
        pulse_job(0);
        wait_idle();
        do_read(0, 1, 8);          // R8 busy poll clears
        do_read(1, 0, 8);          // R8
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, 6, "reads left unanswered", sb.size(), 0); // R6
        done = 1'b1;
    end

    initial begin
        int n;
        n = 0;
        while (!done && n < 100000) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R0 watchdog expired: actual %0d expected %0d", n, 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule